// File: doc/BRIEF.md
# Ternary Search Array with Priority Pick

This block is a small content-searched table. Each of its entries holds a valid flag, a key, and a per-bit care mask in a tag array. A payload word for the same entry sits in a separate data array. A write port loads one entry by index or invalidates it. A search port presents a key. One cycle later the block returns four results: the vector of entries that matched, a flag that is high when any entry matched, the index of the lowest-numbered matching entry, and a payload word.

Two run-time inputs change how a search behaves. The match mode input sets how the care mask is applied: not at all, to both the stored and the searched key, or to the searched key only. The pick mode input sets where the payload comes from. In lowest-index mode it is the payload of the lowest-indexed matching entry. In merge mode it is the bitwise OR of the payloads of every matching entry.

Typical uses are address filters, lookup tables with wildcards, and small associative buffers in which several hits must be turned into one answer.

Top module: `tcam_pick`

## Requirements
- R1: With match mode 0 or 3, a valid entry matches when its stored key equals the search key on every bit.
- R2: With match mode 1, a valid entry matches when (stored key AND mask) equals (search key AND mask). A mask bit of 1 means "compare" and a mask bit of 0 means "ignore".
- R3: With match mode 2, a valid entry matches when the stored key equals (search key AND mask).
- R4: An entry that is not valid never matches. A write with the load flag at 0 invalidates the addressed entry, and reset invalidates all entries.
- R5: With pick mode 0, the index output is the lowest index whose hit bit is set, and the data output is that entry's payload.
- R6: With pick mode 1, the data output is the bitwise OR of the payloads of all matching entries. The index output is still the lowest matching index.
- R7: When no entry matches, the any-hit flag, the index output and the data output are all zero.
- R8: Results are registered. The result-valid output is high in exactly the cycle after each cycle in which the search strobe is high.
- R9: A write and a search in the same cycle give the search the table contents from before that write, including when both address the same entry.
- R10: After reset, every output is zero.
- R11: Bit i of the hit vector is set exactly when entry i matches under the selected mode. The any-hit flag is the OR of the hit vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_valid_i | input | 1 | 1 loads the entry, 0 invalidates it |
| wr_key_i | input | KEY_W | Key to store |
| wr_mask_i | input | KEY_W | Care mask to store (1 = compare) |
| wr_data_i | input | DATA_W | Payload to store |
| srch_en_i | input | 1 | Search strobe |
| srch_key_i | input | KEY_W | Search key |
| match_mode_i | input | 2 | 0/3 exact, 1 mask both sides, 2 mask search key only |
| pick_mode_i | input | 1 | 0 lowest index, 1 OR of all hit payloads |
| rslt_vld_o | output | 1 | Result valid, one cycle after the search strobe |
| hit_vec_o | output | ENTRIES | Per-entry match vector |
| any_hit_o | output | 1 | At least one entry matched |
| win_idx_o | output | IDX_W | Lowest matching index |
| rd_data_o | output | DATA_W | Selected or merged payload |

## Verification
A write and a search can land in the same cycle, and they can address the same entry. The bench provokes this by driving both strobes together. In one case the write invalidates an entry that the search key hits. In the other it rewrites an entry into a form that would newly match the search key. The scoreboard computes the expected result from its model before it applies the write, so any sign of the new contents in that result is reported. Searches that follow the write, with no gap, then confirm that the new contents have taken effect.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [1:0] {
        MATCH_EXACT = 2'd0,
        MATCH_BOTH  = 2'd1,
        MATCH_KEY   = 2'd2,
        MATCH_RSVD  = 2'd3
    } match_mode_e;

    typedef enum logic {
        PICK_LOWEST = 1'b0,
        PICK_MERGE  = 1'b1
    } pick_mode_e;

endpackage

// File: rtl/tcam_tag_array.sv
module tcam_tag_array
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic [KEY_W-1:0]   srch_key,
    input  match_mode_e        mode,
    output logic [ENTRIES-1:0] match_o,
    output logic [ENTRIES-1:0] ent_vld_o
);

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] key;
        logic [KEY_W-1:0] mask;
    } slot_t;

    slot_t [ENTRIES-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            slot_d[wr_idx].vld  = wr_valid;
            slot_d[wr_idx].key  = wr_valid ? wr_key  : '0;
            slot_d[wr_idx].mask = wr_valid ? wr_mask : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic eq;
        always_comb begin
            case (mode)
                MATCH_BOTH: eq = ((slot_q[g].key & slot_q[g].mask) ==
                                  (srch_key & slot_q[g].mask));
                MATCH_KEY:  eq = (slot_q[g].key == (srch_key & slot_q[g].mask));
                default:    eq = (slot_q[g].key == srch_key);
            endcase
        end
        assign match_o[g]   = slot_q[g].vld & eq;
        assign ent_vld_o[g] = slot_q[g].vld;
    end

endmodule

// File: rtl/tcam_picker.sv
module tcam_picker #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [ENTRIES-1:0] onehot_o
);

    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx_o       = IDX_W'(i);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req;

endmodule

// File: rtl/tcam_data_array.sv
module tcam_data_array
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ENTRIES-1:0] hits,
    input  logic [ENTRIES-1:0] onehot,
    input  pick_mode_e         pick,
    output logic [DATA_W-1:0]  rd_data
);

    logic [ENTRIES-1:0][DATA_W-1:0] pay_d, pay_q;
    logic [ENTRIES-1:0]             sel;

    always_comb begin
        pay_d = pay_q;
        if (wr_en && (int'(wr_idx) < ENTRIES))
            pay_d[wr_idx] = wr_valid ? wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pay_q <= '0;
        else        pay_q <= pay_d;
    end

    assign sel = (pick == PICK_MERGE) ? hits : onehot;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            rd_data = rd_data | (pay_q[i] & {DATA_W{sel[i]}});
    end

endmodule

// File: rtl/tcam_pick.sv
module tcam_pick
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               wr_valid_i,
    input  logic [KEY_W-1:0]   wr_key_i,
    input  logic [KEY_W-1:0]   wr_mask_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               srch_en_i,
    input  logic [KEY_W-1:0]   srch_key_i,
    input  logic [1:0]         match_mode_i,
    input  logic               pick_mode_i,
    output logic               rslt_vld_o,
    output logic [ENTRIES-1:0] hit_vec_o,
    output logic               any_hit_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic [DATA_W-1:0]  rd_data_o
);

    typedef struct packed {
        logic               vld;
        logic [ENTRIES-1:0] hits;
        logic               any;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  data;
    } rslt_t;

    rslt_t              rslt_d, rslt_q;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] ent_vld;
    logic [ENTRIES-1:0] win_onehot;
    logic               any_match;
    logic [IDX_W-1:0]   win_idx;
    logic [DATA_W-1:0]  sel_data;
    match_mode_e        mmode;
    pick_mode_e         pmode;

    assign mmode = match_mode_e'(match_mode_i);
    assign pmode = pick_mode_e'(pick_mode_i);

    tcam_tag_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_idx    (wr_idx_i),
        .wr_valid  (wr_valid_i),
        .wr_key    (wr_key_i),
        .wr_mask   (wr_mask_i),
        .srch_key  (srch_key_i),
        .mode      (mmode),
        .match_o   (match_vec),
        .ent_vld_o (ent_vld)
    );

    tcam_picker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req      (match_vec),
        .any_o    (any_match),
        .idx_o    (win_idx),
        .onehot_o (win_onehot)
    );

    tcam_data_array #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_idx   (wr_idx_i),
        .wr_valid (wr_valid_i),
        .wr_data  (wr_data_i),
        .hits     (match_vec),
        .onehot   (win_onehot),
        .pick     (pmode),
        .rd_data  (sel_data)
    );

    always_comb begin
        rslt_d     = rslt_q;
        rslt_d.vld = srch_en_i;
        if (srch_en_i) begin
            rslt_d.hits = match_vec;
            rslt_d.any  = any_match;
            rslt_d.idx  = win_idx;
            rslt_d.data = sel_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rslt_q <= '0;
        else        rslt_q <= rslt_d;
    end

    assign rslt_vld_o = rslt_q.vld;
    assign hit_vec_o  = rslt_q.hits;
    assign any_hit_o  = rslt_q.any;
    assign win_idx_o  = rslt_q.idx;
    assign rd_data_o  = rslt_q.data;

endmodule

// File: rtl/tcam_pick_chk.sv
module tcam_pick_chk #(
    parameter int ENTRIES = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch_en_i,
    input logic               rslt_vld_o,
    input logic [ENTRIES-1:0] hit_vec_o,
    input logic               any_hit_o,
    input logic [IDX_W-1:0]   win_idx_o,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic [ENTRIES-1:0] ent_vld
);

    // R8
    rslt_follows_srch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en_i |=> rslt_vld_o);

    // R8
    no_spurious_rslt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en_i |=> !rslt_vld_o);

    // R4
    invalid_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en_i |=> ((hit_vec_o & ~$past(ent_vld)) == '0));

    // R11
    any_hit_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_vld_o |-> (any_hit_o == (|hit_vec_o)));

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_vld_o && !any_hit_o) |-> (win_idx_o == '0 && rd_data_o == '0));

    // R5
    lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_vld_o && any_hit_o) |->
            (hit_vec_o[win_idx_o] &&
             ((hit_vec_o & ~({ENTRIES{1'b1}} << win_idx_o)) == '0)));

endmodule

bind tcam_pick tcam_pick_chk #(
    .ENTRIES (ENTRIES),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_en_i  (srch_en_i),
    .rslt_vld_o (rslt_vld_o),
    .hit_vec_o  (hit_vec_o),
    .any_hit_o  (any_hit_o),
    .win_idx_o  (win_idx_o),
    .rd_data_o  (rd_data_o),
    .ent_vld    (ent_vld)
);

// File: tb/tcam_pick_tb_top.sv
module tcam_pick_tb_top;

    localparam int N = 8;
    localparam int K = 8;
    localparam int D = 8;
    localparam int I = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [I-1:0] wr_idx = '0;
    logic         wr_valid = 1'b0;
    logic [K-1:0] wr_key = '0;
    logic [K-1:0] wr_mask = '0;
    logic [D-1:0] wr_data = '0;
    logic         srch_en = 1'b0;
    logic [K-1:0] srch_key = '0;
    logic [1:0]   mmode = '0;
    logic         pmode = 1'b0;
    logic         rslt_vld;
    logic [N-1:0] hit_vec;
    logic         any_hit;
    logic [I-1:0] win_idx;
    logic [D-1:0] rd_data;

    always #4ns clk = ~clk;

    tcam_pick #(.ENTRIES(N), .KEY_W(K), .DATA_W(D)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_valid_i   (wr_valid),
        .wr_key_i     (wr_key),
        .wr_mask_i    (wr_mask),
        .wr_data_i    (wr_data),
        .srch_en_i    (srch_en),
        .srch_key_i   (srch_key),
        .match_mode_i (mmode),
        .pick_mode_i  (pmode),
        .rslt_vld_o   (rslt_vld),
        .hit_vec_o    (hit_vec),
        .any_hit_o    (any_hit),
        .win_idx_o    (win_idx),
        .rd_data_o    (rd_data)
    );

    typedef struct {
        logic [N-1:0] hits;
        logic         any;
        logic [I-1:0] idx;
        logic [D-1:0] data;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    logic         m_vld [N];
    logic [K-1:0] m_key [N];
    logic [K-1:0] m_msk [N];
    logic [D-1:0] m_dat [N];

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [K-1:0] key, input logic [1:0] mm,
                                     input logic pm, input string tag);
        exp_t e;
        logic hit;
        e.hits = '0; e.any = 1'b0; e.idx = '0; e.data = '0; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            case (mm)
                2'd1:    hit = ((m_key[i] & m_msk[i]) == (key & m_msk[i]));
                2'd2:    hit = (m_key[i] == (key & m_msk[i]));
                default: hit = (m_key[i] == key);
            endcase
            e.hits[i] = m_vld[i] & hit;
        end
        for (int i = N - 1; i >= 0; i--)
            if (e.hits[i]) e.idx = I'(i);
        e.any = |e.hits;
        if (e.any) begin
            if (pm) begin
                for (int i = 0; i < N; i++)
                    if (e.hits[i]) e.data = e.data | m_dat[i];
            end else begin
                e.data = m_dat[e.idx];
            end
        end
        return e;
    endfunction

    task automatic model_write(input int idx, input bit v, input logic [K-1:0] key,
                               input logic [K-1:0] msk, input logic [D-1:0] dat);
        m_vld[idx] = v;
        m_key[idx] = v ? key : '0;
        m_msk[idx] = v ? msk : '0;
        m_dat[idx] = v ? dat : '0;
    endtask

    task automatic do_write(input int idx, input bit v, input logic [K-1:0] key,
                            input logic [K-1:0] msk, input logic [D-1:0] dat);
        @(negedge clk);
        srch_en = 1'b0;
        wr_en = 1'b1; wr_idx = I'(idx); wr_valid = v;
        wr_key = key; wr_mask = msk; wr_data = dat;
        model_write(idx, v, key, msk, dat);
    endtask

    task automatic do_search(input logic [K-1:0] key, input logic [1:0] mm,
                             input logic pm, input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        srch_en = 1'b1; srch_key = key; mmode = mm; pmode = pm;
        sb_q.push_back(predict(key, mm, pm, tag));
    endtask

    task automatic do_both(input int idx, input bit v, input logic [K-1:0] wkey,
                           input logic [K-1:0] msk, input logic [D-1:0] dat,
                           input logic [K-1:0] skey, input logic [1:0] mm,
                           input logic pm, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = I'(idx); wr_valid = v;
        wr_key = wkey; wr_mask = msk; wr_data = dat;
        srch_en = 1'b1; srch_key = skey; mmode = mm; pmode = pm;
        sb_q.push_back(predict(skey, mm, pm, tag));
        model_write(idx, v, wkey, msk, dat);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            wr_en = 1'b0;
            srch_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor: samples at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rslt_vld) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "result without search", 32'(rslt_vld), 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(hit_vec == e.hits, e.tag, "hit vector", 32'(hit_vec), 32'(e.hits));
                    check(any_hit == e.any, e.tag, "any hit", 32'(any_hit), 32'(e.any));
                    check(win_idx == e.idx, e.tag, "index", 32'(win_idx), 32'(e.idx));
                    check(rd_data == e.data, e.tag, "data", 32'(rd_data), 32'(e.data));
                end
            end else if (rst_n && sb_q.size() != 0 && !srch_en) begin
                // R8: a pending search must have produced its result by now
                check(1'b0, "R8", "missing result", 32'(rslt_vld), 32'd1);
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        #(8ns * 100000);
        check(1'b0, "WATCHDOG", "timeout", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) model_write(i, 1'b0, '0, '0, '0);
        repeat (3) @(negedge clk);
        // R10: outputs at zero while in reset
        check({rslt_vld, hit_vec, any_hit, win_idx, rd_data} == '0, "R10",
              "outputs in reset", 32'(rd_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({rslt_vld, hit_vec, any_hit, win_idx, rd_data} == '0, "R10",
              "outputs after reset", 32'(hit_vec), 32'd0);
        // R10/R4: fresh table holds no valid entry, even for key zero
        do_search(8'h00, 2'd0, 1'b0, "R10");
        do_search(8'h00, 2'd1, 1'b1, "R4");
        idle(2);

        do_write(0, 1'b1, 8'hA5, 8'hFF, 8'h01);
        do_write(1, 1'b1, 8'hA0, 8'hF0, 8'h02);
        do_write(2, 1'b1, 8'h30, 8'hF0, 8'h04);
        do_write(3, 1'b1, 8'hA5, 8'hFF, 8'h08);
        do_write(5, 1'b1, 8'h5A, 8'h0F, 8'h10);
        do_write(6, 1'b1, 8'hA7, 8'h00, 8'h20);
        idle(1);

        do_search(8'hA5, 2'd0, 1'b0, "R5");   // R1: two exact hits, lowest wins
        do_search(8'hA5, 2'd0, 1'b1, "R6");   // OR of entries 0 and 3
        do_search(8'hA5, 2'd3, 1'b0, "R1");   // code 3 behaves as exact
        do_search(8'hA7, 2'd1, 1'b0, "R2");   // masked both sides
        do_search(8'hA7, 2'd1, 1'b1, "R6");
        do_search(8'h3C, 2'd2, 1'b0, "R3");   // search key masked only
        do_search(8'h3C, 2'd1, 1'b1, "R2");
        do_search(8'h77, 2'd0, 1'b0, "R7");   // no hit
        do_search(8'h77, 2'd0, 1'b1, "R7");
        idle(2);

        // R4: invalidate entry 0; entry 3 then wins
        do_write(0, 1'b0, 8'h00, 8'h00, 8'h00);
        do_search(8'hA5, 2'd0, 1'b0, "R4");
        do_search(8'h00, 2'd0, 1'b0, "R4");    // cleared key zero must not hit
        idle(1);

        // R9: write and search on the same entry in one cycle
        do_both(3, 1'b0, 8'h00, 8'h00, 8'h00, 8'hA5, 2'd0, 1'b0, "R9");
        do_search(8'hA5, 2'd0, 1'b0, "R9");
        do_both(4, 1'b1, 8'h77, 8'hFF, 8'h40, 8'h77, 2'd0, 1'b1, "R9");
        do_search(8'h77, 2'd0, 1'b1, "R9");
        idle(2);

        // R11: mixed pattern sweep across modes
        for (int t = 0; t < 60; t++) begin
            logic [K-1:0] k;
            k = m_key[$urandom % N];
            if ($urandom % 2) k = k ^ K'(1 << ($urandom % K));
            do_search(k, 2'($urandom % 4), 1'($urandom % 2), "R11");
            if (t % 7 == 6) idle(1);
        end
        idle(3);
        check(sb_q.size() == 0, "R8", "queue drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule